// File: doc/BRIEF.md
# Width-Generic Logic and Arithmetic Unit with Carry/Borrow

This block is a purely combinational unit of configurable width. It accepts two unsigned operands of `WIDTH` bits and a two-bit operation code, and produces a `WIDTH`-bit result plus one flag bit. The four operations are bitwise AND, bitwise OR, addition and subtraction. The flag reports the carry out of an addition or the borrow out of a subtraction, and is always low for the two bitwise operations.

Both arithmetic operations work on a result word one bit wider than the operands. Each operand is widened with a leading zero, not with a copy of its top bit. The flag is the top bit of that wide word, and the visible result is the word's lower `WIDTH` bits. Because operands are widened with zeros, the flag is an unsigned carry or borrow and never a signed overflow indication.

A parameter selects how the wide adder/subtractor is built. One option is an explicit bit-level ripple chain made by a generate loop. The other is a single arithmetic expression that synthesis maps as it sees fit. Every operation code drives the whole wide word, so the block holds no state.

Top module: `carry_alu`

## Requirements
- R1: Operation code 2'b00 gives result = A AND B (bitwise), with the flag at 0.
- R2: Operation code 2'b01 gives result = A OR B (bitwise), with the flag at 0.
- R3: Operation code 2'b10 gives {flag, result} = A + B, where both operands are zero-extended to WIDTH+1 bits, so the flag is the unsigned carry out.
- R4: Operation code 2'b11 gives result = (A - B) mod 2^WIDTH. The flag is 1 exactly when A < B as unsigned numbers.
- R5: At WIDTH=4, adding 4'b0101 and 4'b1001 gives result 4'b1110 with the flag at 0. This shows that a set top operand bit is not sign-extended.
- R6: At WIDTH=4, adding 4'b1111 and 4'b0001 gives result 4'b0000 with the flag at 1. This is the carry boundary.
- R7: Subtracting equal operands gives result 0 with the flag at 0. Subtracting 1 from 0 gives all ones with the flag at 1.
- R8: The outputs depend only on the present inputs. With all inputs at zero the outputs are zero. A new input value shows at the outputs in the same cycle, and no earlier operation leaves any trace.
- R9: Both adder build options (ripple chain and arithmetic expression) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First unsigned operand |
| opnd_b | input | WIDTH | Second unsigned operand |
| op_sel | input | 2 | Operation code: 00 AND, 01 OR, 10 add, 11 subtract |
| result | output | WIDTH | Low WIDTH bits of the wide internal result |
| carry_out | output | 1 | Carry (add) or borrow (subtract); 0 for AND and OR |

## Verification
At the default width of four, every operand pair is applied under all four operation codes. This covers, for example, the case of a top operand bit being set but no carry occurring, which sign extension would get wrong. It also covers the exact point where A crosses B, where the borrow must switch. Seeded random pairs, with the operation code changing on each one, confirm that no operation leaves anything behind for the next. Directed cases cover the all-ones carry, the zero-minus-one borrow, equal operands, and the zero-input state. Two instances, one per adder build option, are compared against the same reference and therefore against each other.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

   typedef enum logic [1:0] {
      OPC_AND = 2'b00,
      OPC_OR  = 2'b01,
      OPC_ADD = 2'b10,
      OPC_SUB = 2'b11
   } opc_e;

   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_EXPR   = 1;

   function automatic logic is_arith(input opc_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/carry_alu_logic.sv
module carry_alu_logic #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             use_or_i,
   output logic [WIDTH:0]   wide_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("carry_alu_logic: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] bits;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bits[i] = use_or_i ? (a_i[i] | b_i[i]) : (a_i[i] & b_i[i]);
   end

   // top bit is tied low: bitwise operations never raise the flag
   assign wide_o = {1'b0, bits};

endmodule

// File: rtl/carry_alu_arith.sv
module carry_alu_arith #(
   parameter int WIDTH       = 4,
   parameter int ADDER_STYLE = carry_alu_pkg::ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH:0]   wide_o
);
   localparam int EXT_W = WIDTH + 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("carry_alu_arith: WIDTH must be at least 1");
   end
   if (ADDER_STYLE != carry_alu_pkg::ADDER_RIPPLE &&
       ADDER_STYLE != carry_alu_pkg::ADDER_EXPR) begin : g_bad_style
      $error("carry_alu_arith: unknown ADDER_STYLE");
   end

   // zero extension: the added top bit is 0, never a copy of the msb
   logic [EXT_W-1:0] ext_a;
   logic [EXT_W-1:0] ext_b;
   assign ext_a = {1'b0, a_i};
   assign ext_b = {1'b0, b_i};

   if (ADDER_STYLE == carry_alu_pkg::ADDER_RIPPLE) begin : g_ripple
      logic [EXT_W:0]   chain;
      logic [EXT_W-1:0] b_eff;
      logic [EXT_W-1:0] sum;
      assign chain[0] = sub_i;
      for (genvar i = 0; i < EXT_W; i++) begin : g_stage
         assign b_eff[i]   = ext_b[i] ^ sub_i;
         assign sum[i]     = ext_a[i] ^ b_eff[i] ^ chain[i];
         assign chain[i+1] = (ext_a[i] & b_eff[i]) | (chain[i] & (ext_a[i] ^ b_eff[i]));
      end
      assign wide_o = sum;
   end else begin : g_expr
      assign wide_o = sub_i ? (ext_a - ext_b) : (ext_a + ext_b);
   end

   always_comb begin
      if (!sub_i) begin
         // a sum of zero-extended operands never wraps below either operand
         assert_add_no_wrap_R3: assert (wide_o >= ext_a && wide_o >= ext_b);
      end
      if (sub_i) begin
         assert_sub_borrow_R4: assert (wide_o[WIDTH] == (a_i < b_i));
      end
      if (sub_i && a_i == b_i) begin
         assert_sub_equal_zero_R7: assert (wide_o == '0);
      end
   end

endmodule

// File: rtl/carry_alu.sv
module carry_alu #(
   parameter int WIDTH       = 4,
   parameter int ADDER_STYLE = carry_alu_pkg::ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [1:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   import carry_alu_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("carry_alu: WIDTH must be at least 1");
   end

   opc_e           opc;
   logic [WIDTH:0] logic_wide;
   logic [WIDTH:0] arith_wide;
   logic [WIDTH:0] wide_res;

   assign opc = opc_e'(op_sel);

   carry_alu_logic #(
      .WIDTH (WIDTH)
   ) u_logic (
      .a_i      (opnd_a),
      .b_i      (opnd_b),
      .use_or_i (op_sel[0]),
      .wide_o   (logic_wide)
   );

   carry_alu_arith #(
      .WIDTH       (WIDTH),
      .ADDER_STYLE (ADDER_STYLE)
   ) u_arith (
      .a_i    (opnd_a),
      .b_i    (opnd_b),
      .sub_i  (op_sel[0]),
      .wide_o (arith_wide)
   );

   // every code drives the full wide word
   always_comb begin
      if (is_arith(opc)) wide_res = arith_wide;
      else               wide_res = logic_wide;
   end

   assign result    = wide_res[WIDTH-1:0];
   assign carry_out = wide_res[WIDTH];

   always_comb begin
      if (opc == OPC_AND) begin
         assert_and_subset_R1: assert ((result & ~opnd_a) == '0 && carry_out == 1'b0);
      end
      if (opc == OPC_OR) begin
         assert_or_superset_R2: assert ((result & opnd_b) == opnd_b && carry_out == 1'b0);
      end
   end

endmodule

// File: tb/tb_carry_alu.sv
module tb_carry_alu;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic [W-1:0] opnd_a = '0;
   logic [W-1:0] opnd_b = '0;
   logic [1:0]   op_sel = 2'b00;
   logic [W-1:0] result, result_x;
   logic         carry_out, carry_x;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   carry_alu #(.WIDTH(W), .ADDER_STYLE(0)) dut (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
      .result(result), .carry_out(carry_out));

   carry_alu #(.WIDTH(W), .ADDER_STYLE(1)) dut_expr (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
      .result(result_x), .carry_out(carry_x));

   function automatic logic [W:0] ref_wide(input logic [1:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
      logic [W:0] za = {1'b0, a};
      logic [W:0] zb = {1'b0, b};
      case (op)
         2'b00:   return {1'b0, a & b};
         2'b01:   return {1'b0, a | b};
         2'b10:   return za + zb;
         default: return za - zb;
      endcase
   endfunction

   function automatic string op_tag(input logic [1:0] op);
      case (op)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: op=%b a=%b b=%b got {c,r}=%b expected %b",
                  tag, op_sel, opnd_a, opnd_b, got, exp);
      end
   endtask

   task automatic apply(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string tag);
      @(negedge clk);
      op_sel = op;
      opnd_a = a;
      opnd_b = b;
      #1;
      check(tag, {carry_out, result}, ref_wide(op, a, b));
      check("R9", {carry_x, result_x}, ref_wide(op, a, b));
   endtask

   initial begin
      int unsigned seed_v;
      @(negedge clk);
      #1;
      // R8: all-zero inputs give all-zero outputs
      check("R8", {carry_out, result}, '0);

      // R5: top bit set but no carry (zero extension)
      apply(2'b10, 4'b0101, 4'b1001, "R5");
      check("R5", {carry_out, result}, 5'b0_1110);
      // R6: carry boundary
      apply(2'b10, 4'b1111, 4'b0001, "R6");
      check("R6", {carry_out, result}, 5'b1_0000);
      // R7: equal operands and zero minus one
      apply(2'b11, 4'b1010, 4'b1010, "R7");
      check("R7", {carry_out, result}, 5'b0_0000);
      apply(2'b11, 4'b0000, 4'b0001, "R7");
      check("R7", {carry_out, result}, 5'b1_1111);
      // R1 R2: logic ops keep flag low even with all ones
      apply(2'b00, 4'b1111, 4'b1111, "R1");
      check("R1", {carry_out, result}, 5'b0_1111);
      apply(2'b01, 4'b1111, 4'b0000, "R2");
      check("R2", {carry_out, result}, 5'b0_1111);

      // exhaustive sweep
      for (int op = 0; op < 4; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               apply(op[1:0], a[W-1:0], b[W-1:0], op_tag(op[1:0]));

      // R8: seeded random, operation changes every vector
      seed_v = $urandom(32'h5EED_0042);
      for (int k = 0; k < 400; k++) begin
         int unsigned r = $urandom();
         apply(r[1:0], r[5:2], r[9:6], "R8");
      end

      // R8: after a carry-producing add, a zero AND shows no trace
      apply(2'b10, 4'b1111, 4'b1111, "R3");
      apply(2'b00, 4'b0000, 4'b0000, "R8");
      check("R8", {carry_out, result}, 5'b0_0000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, got no completion expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule